// File: doc/BRIEF.md
# DDS Channel Initialization Sequencer

This block brings one channel of a multi-channel direct digital synthesizer out of reset. A single start pulse triggers a fixed series of register writes on a parallel address/data bus. Each write takes a fixed slot of bus clocks. Partway through the series, the sequencer pauses for a long, parameterized interval so that the converter can finish calibrating.

A mode input selects between two variants. The plain variant configures the channel and runs one calibration. The synchronized variant runs a calibration first. It then enables sync output, programs the sync delay field, runs a second calibration, and only after that applies the output configuration. The channel index, mode and sync delay are captured when the start pulse is accepted. A one-cycle done pulse marks the end of the series.

Top module: `dds_chan_init`

## Requirements
- R1: While reset is asserted and afterwards with no start, `wr_o`, `done_o`, `addr_o` and `data_o` are all zero.
- R2: Every write occupies a slot of SLOT_CYCLES (default 5) clocks. `wr_o` is high only in the first clock of the slot, and `addr_o`/`data_o` hold their value for the whole slot. Outside a slot, the address and data are zero. A slot that is not followed by a calibration wait is followed immediately by the next slot.
- R3: The first write goes to address 0x81 with data `1 << (chan_i + 1)`. A channel index of NUM_CH or more gives data 0.
- R4: With `sync_mode_i`=0, the writes are, as (address, data): (0x81, select), (0x03, 0x0000), (0x05, 0x8900), (0x07, 0x0080), (0x33, 0x0FFF), (0x0F, 0x0105), (0x80, 0), (0x0F, 0x0005), (0x80, 0).
- R5: Exactly CAL_CYCLES clocks with no slot separate the end of the slot of each update write that starts a calibration from the start of the next slot. The plain variant has one such wait, after its first update write.
- R6: With `sync_mode_i`=1, the writes are: (0x81, select), (0x0F, 0x0105), (0x80, 0) + wait, (0x0F, 0x0005), (0x80, 0), (0x05, 0x8B00), (0x80, 0), (0x6D, sync), (0x80, 0), (0x0F, 0x0105), (0x80, 0) + wait, (0x0F, 0x0005), (0x80, 0), (0x03, 0x0000), (0x07, 0x0080), (0x33, 0x0FFF), (0x80, 0).
- R7: The sync write to address 0x6D carries `0x0840 | sync_dly_i`, where `sync_dly_i` fills bits 5:0.
- R8: The first write strobe appears in the clock after the clock in which start is sampled. `done_o` is high for exactly one clock, the clock after the last slot ends.
- R9: A start pulse arriving from the first slot through the done clock is ignored. Changes on `chan_i`, `sync_mode_i` and `sync_dly_i` after start has been accepted have no effect. No write follows done unless a new start arrives.
- R10: A start in the clock right after the done clock is accepted and starts a new series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| chan_i | input | CH_W (2) | Channel index to initialize |
| sync_mode_i | input | 1 | 0 = plain variant, 1 = synchronized variant |
| sync_dly_i | input | 6 | Sync in/out delay field |
| addr_o | output | 8 | Register address of the current write |
| data_o | output | 16 | Data of the current write |
| wr_o | output | 1 | Write strobe, first clock of each slot |
| done_o | output | 1 | One-clock pulse after the final write |

## Verification
The checker watches four things on every cycle: the spacing of strobes, the hold of address and data within a slot, zero data outside slots, and a single-clock done. It also checks that done is always preceded by an update write and is never followed directly by a write. The exact write order, the channel select and sync delay values, and the length of each calibration gap can only be shown by the bench scenarios. The same holds for the latching of inputs, ignored mid-run starts and back-to-back starts. The bench replays each variant against an independently built expected list.

// File: rtl/dds_init_pkg.sv
package dds_init_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DLY_W  = 6;
  localparam int STEP_W = 5;

  localparam logic [ADDR_W-1:0] A_SEL   = 8'h81;
  localparam logic [ADDR_W-1:0] A_UPD   = 8'h80;
  localparam logic [ADDR_W-1:0] A_CTL1H = 8'h03;
  localparam logic [ADDR_W-1:0] A_CTL2L = 8'h05;
  localparam logic [ADDR_W-1:0] A_CTL2H = 8'h07;
  localparam logic [ADDR_W-1:0] A_AMP   = 8'h33;
  localparam logic [ADDR_W-1:0] A_CTL4H = 8'h0F;
  localparam logic [ADDR_W-1:0] A_SYNC  = 8'h6D;

  localparam logic [DATA_W-1:0] SYNC_BASE = 16'h0840;

  typedef enum logic [1:0] {SRC_CONST, SRC_SEL, SRC_SYNC} dsrc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_CAL, ST_FIN} state_e;

  typedef struct packed {
    dsrc_e             src;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              cal_after;
    logic              last;
  } step_t;

  function automatic step_t mk(dsrc_e s, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                               logic c, logic l);
    step_t r;
    r.src = s; r.addr = a; r.data = d; r.cal_after = c; r.last = l;
    return r;
  endfunction
endpackage

// File: rtl/dds_init_rom.sv
module dds_init_rom
  import dds_init_pkg::*;
(
  input  logic              sync_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);
  always_comb begin
    step_o = mk(SRC_CONST, A_UPD, 16'h0000, 1'b0, 1'b1);
    if (!sync_i) begin
      case (idx_i)
        5'd0: step_o = mk(SRC_SEL,   A_SEL,   16'h0000, 1'b0, 1'b0);
        5'd1: step_o = mk(SRC_CONST, A_CTL1H, 16'h0000, 1'b0, 1'b0);
        5'd2: step_o = mk(SRC_CONST, A_CTL2L, 16'h8900, 1'b0, 1'b0);
        5'd3: step_o = mk(SRC_CONST, A_CTL2H, 16'h0080, 1'b0, 1'b0);
        5'd4: step_o = mk(SRC_CONST, A_AMP,   16'h0FFF, 1'b0, 1'b0);
        5'd5: step_o = mk(SRC_CONST, A_CTL4H, 16'h0105, 1'b0, 1'b0);
        5'd6: step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b1, 1'b0);
        5'd7: step_o = mk(SRC_CONST, A_CTL4H, 16'h0005, 1'b0, 1'b0);
        default: ;
      endcase
    end else begin
      case (idx_i)
        5'd0:  step_o = mk(SRC_SEL,   A_SEL,   16'h0000, 1'b0, 1'b0);
        5'd1:  step_o = mk(SRC_CONST, A_CTL4H, 16'h0105, 1'b0, 1'b0);
        5'd2:  step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b1, 1'b0);
        5'd3:  step_o = mk(SRC_CONST, A_CTL4H, 16'h0005, 1'b0, 1'b0);
        5'd4:  step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b0, 1'b0);
        5'd5:  step_o = mk(SRC_CONST, A_CTL2L, 16'h8B00, 1'b0, 1'b0);
        5'd6:  step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b0, 1'b0);
        5'd7:  step_o = mk(SRC_SYNC,  A_SYNC,  16'h0000, 1'b0, 1'b0);
        5'd8:  step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b0, 1'b0);
        5'd9:  step_o = mk(SRC_CONST, A_CTL4H, 16'h0105, 1'b0, 1'b0);
        5'd10: step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b1, 1'b0);
        5'd11: step_o = mk(SRC_CONST, A_CTL4H, 16'h0005, 1'b0, 1'b0);
        5'd12: step_o = mk(SRC_CONST, A_UPD,   16'h0000, 1'b0, 1'b0);
        5'd13: step_o = mk(SRC_CONST, A_CTL1H, 16'h0000, 1'b0, 1'b0);
        5'd14: step_o = mk(SRC_CONST, A_CTL2H, 16'h0080, 1'b0, 1'b0);
        5'd15: step_o = mk(SRC_CONST, A_AMP,   16'h0FFF, 1'b0, 1'b0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dds_init_slot_timer.sv
module dds_init_slot_timer #(
  parameter  int unsigned SLOT_CYCLES = 5,
  localparam int          CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] CMAX = CW'(SLOT_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || cnt_q == CMAX) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == CMAX);
endmodule

// File: rtl/dds_init_cal_timer.sv
module dds_init_cal_timer #(
  parameter  int unsigned CAL_CYCLES = 147000,
  localparam int          CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] CMAX = CW'(CAL_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || cnt_q == CMAX) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == CMAX);
endmodule

// File: rtl/dds_chan_init.sv
module dds_chan_init
  import dds_init_pkg::*;
#(
  parameter  int unsigned NUM_CH      = 3,
  parameter  int unsigned SLOT_CYCLES = 5,
  parameter  int unsigned CAL_CYCLES  = 147000,
  localparam int          CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              sync_mode_i,
  input  logic [DLY_W-1:0]  sync_dly_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_o,
  output logic              done_o
);
  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [CH_W-1:0]   ch_q;
  logic              sync_q;
  logic [DLY_W-1:0]  dly_q;
  step_t             step;
  logic              slot_first, slot_last, cal_last;
  logic [DATA_W-1:0] sel_data, step_data;

  dds_init_rom u_rom (
    .sync_i (sync_q),
    .idx_i  (step_q),
    .step_o (step)
  );

  dds_init_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_WRITE),
    .first_o (slot_first),
    .last_o  (slot_last)
  );

  dds_init_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_CAL),
    .last_o (cal_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      ch_q    <= '0;
      sync_q  <= 1'b0;
      dly_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          ch_q    <= chan_i;
          sync_q  <= sync_mode_i;
          dly_q   <= sync_dly_i;
          step_q  <= '0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (slot_last) begin
          if (step.last) state_q <= ST_FIN;
          else begin
            step_q <= step_q + 1'b1;
            if (step.cal_after) state_q <= ST_CAL;
          end
        end
        ST_CAL:  if (cal_last) state_q <= ST_WRITE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // one-hot select starts at bit 1; out-of-range channel selects none
  always_comb begin
    sel_data = '0;
    if (32'(ch_q) < NUM_CH) sel_data = DATA_W'(1) << (32'(ch_q) + 1);
  end

  always_comb begin
    case (step.src)
      SRC_SEL:  step_data = sel_data;
      SRC_SYNC: step_data = SYNC_BASE | DATA_W'(dly_q);
      default:  step_data = step.data;
    endcase
  end

  assign addr_o = (state_q == ST_WRITE) ? step.addr : '0;
  assign data_o = (state_q == ST_WRITE) ? step_data : '0;
  assign wr_o   = slot_first;
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/dds_chan_init_chk.sv
module dds_chan_init_chk
  import dds_init_pkg::*;
#(
  parameter  int unsigned SLOT_CYCLES = 5,
  localparam int          GW = $clog2(SLOT_CYCLES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o,
  input logic              wr_o,
  input logic              done_o
);
  logic [GW-1:0] gap_q;
  localparam logic [GW-1:0] GSAT = GW'(SLOT_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= GSAT;
    else if (wr_o)         gap_q <= GW'(1);
    else if (gap_q < GSAT) gap_q <= gap_q + 1'b1;
  end

  // R2
  wr_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> gap_q >= GSAT);

  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o != '0 && !wr_o) |-> (addr_o == $past(addr_o) && data_o == $past(data_o)));

  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o == '0) |-> (data_o == '0 && !wr_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(addr_o) == A_UPD && addr_o == '0 && !wr_o));

  // R9
  no_wr_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !wr_o);
endmodule

bind dds_chan_init dds_chan_init_chk #(.SLOT_CYCLES(SLOT_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .data_o (data_o),
  .wr_o   (wr_o),
  .done_o (done_o)
);

// File: tb/sim_dds_chan_init.sv
module sim_dds_chan_init;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 5;
  localparam int CAL  = 20;
  localparam int NCH  = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smode = 1'b0;
  logic [1:0] chan = '0;
  logic [5:0] dly = '0;
  logic [7:0] addr;
  logic [15:0] data;
  logic wr, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_chan_init #(.NUM_CH(NCH), .SLOT_CYCLES(SLOT), .CAL_CYCLES(CAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan),
    .sync_mode_i(smode), .sync_dly_i(dly),
    .addr_o(addr), .data_o(data), .wr_o(wr), .done_o(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_log = 0, n_done = 0;
  int log_a[512], log_d[512], log_c[512], done_c[64];
  always @(negedge clk) begin
    if (wr && n_log < 512) begin
      log_a[n_log] = addr; log_d[n_log] = data; log_c[n_log] = cyc; n_log++;
    end
    if (done && n_done < 64) begin
      done_c[n_done] = cyc; n_done++;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // expected (address, data, calibration-after) per step from the requirements
  task automatic exp_step(input bit m, input int k, input int ch, input int dl,
                          output int a, output int d, output bit w);
    int sel = (ch < NCH) ? (1 << (ch + 1)) : 0;
    w = 0; a = 'h80; d = 0;
    if (!m) begin
      case (k)
        0: begin a = 'h81; d = sel; end
        1: begin a = 'h03; d = 'h0000; end
        2: begin a = 'h05; d = 'h8900; end
        3: begin a = 'h07; d = 'h0080; end
        4: begin a = 'h33; d = 'h0FFF; end
        5: begin a = 'h0F; d = 'h0105; end
        6: w = 1;
        7: begin a = 'h0F; d = 'h0005; end
        default: ;
      endcase
    end else begin
      case (k)
        0:  begin a = 'h81; d = sel; end
        1:  begin a = 'h0F; d = 'h0105; end
        2:  w = 1;
        3:  begin a = 'h0F; d = 'h0005; end
        5:  begin a = 'h05; d = 'h8B00; end
        7:  begin a = 'h6D; d = 'h0840 | dl; end
        9:  begin a = 'h0F; d = 'h0105; end
        10: w = 1;
        11: begin a = 'h0F; d = 'h0005; end
        13: begin a = 'h03; d = 'h0000; end
        14: begin a = 'h07; d = 'h0080; end
        15: begin a = 'h33; d = 'h0FFF; end
        default: ;
      endcase
    end
  endtask

  task automatic launch(input bit m, input int ch, input int dl, output int st);
    @(negedge clk);
    smode = m; chan = 2'(ch); dly = 6'(dl); start = 1'b1; st = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int dbase);
    int t = 0;
    while (n_done <= dbase && t < 5000) begin
      @(negedge clk); #1; t++;
    end
  endtask

  task automatic verify(input bit m, input int ch, input int dl,
                        input int base, input int dbase, input int st);
    int nexp = m ? 17 : 9;
    int cnt = 0, dc, a, d;
    bit w, pw = 0;
    string req;
    if (n_done <= dbase) begin
      check(1'b0, "R8", "done missing", 0, 1);
      return;
    end
    dc = done_c[dbase];
    for (int i = base; i < n_log; i++) if (log_c[i] < dc) cnt++;
    check(cnt == nexp, m ? "R6" : "R4", "write count", cnt, nexp);
    if (cnt != nexp) return;
    for (int k = 0; k < nexp; k++) begin
      exp_step(m, k, ch, dl, a, d, w);
      req = (k == 0) ? "R3" : (m && k == 7) ? "R7" : m ? "R6" : "R4";
      check(log_a[base+k] == a && log_d[base+k] == d, req, $sformatf("write %0d addr/data", k),
            (log_a[base+k] << 16) | log_d[base+k], (a << 16) | d);
      if (k == 0)
        check(log_c[base] == st + 1, "R8", "first strobe cycle", log_c[base], st + 1);
      else
        check(log_c[base+k] - log_c[base+k-1] == SLOT + (pw ? CAL : 0), pw ? "R5" : "R2",
              $sformatf("gap before write %0d", k), log_c[base+k] - log_c[base+k-1],
              SLOT + (pw ? CAL : 0));
      pw = w;
    end
    check(dc == log_c[base+nexp-1] + SLOT, "R8", "done cycle", dc, log_c[base+nexp-1] + SLOT);
  endtask

  task automatic quiet(input int dbase, input int nlog_exp);
    repeat (2*SLOT + CAL) @(negedge clk);
    #1;
    check(n_log == nlog_exp, "R9", "writes after done", n_log, nlog_exp);
    check(n_done == dbase + 1, "R8", "done pulse count", n_done, dbase + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!wr && !done && addr == 0 && data == 0, "R1", "outputs in reset",
          {wr, done, addr, data}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(n_log == 0 && n_done == 0 && addr == 0 && data == 0, "R1", "idle after reset",
          n_log + n_done, 0);
  endtask

  task automatic t_run(input bit m, input int ch, input int dl);
    int base = n_log, db = n_done, st;
    launch(m, ch, dl, st);
    wait_done(db);
    verify(m, ch, dl, base, db, st);
    quiet(db, base + (m ? 17 : 9));
  endtask

  // R9: mid-run starts and input changes are ignored
  task automatic t_busy_start();
    int base = n_log, db = n_done, st;
    launch(1'b0, 1, 0, st);
    chan = 2'd2; smode = 1'b1; dly = 6'h3F;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (SLOT*6 + 3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(db);
    start = 1'b1; @(negedge clk); start = 1'b0;
    verify(1'b0, 1, 0, base, db, st);
    quiet(db, base + 9);
  endtask

  // R10: start in the clock right after done
  task automatic t_back_to_back();
    int base = n_log, db = n_done, st1, st2;
    launch(1'b0, 2, 0, st1);
    wait_done(db);
    launch(1'b1, 1, 'h3F, st2);
    verify(1'b0, 2, 0, base, db, st1);
    wait_done(db + 1);
    check(n_log > base + 9 && log_c[base+9] == st2 + 1, "R10", "restart strobe cycle",
          log_c[base+9], st2 + 1);
    verify(1'b1, 1, 'h3F, base + 9, db + 1, st2);
    quiet(db + 1, base + 26);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_run(1'b0, 0, 0);
    t_run(1'b0, 2, 'h2A);
    t_run(1'b0, 3, 0);
    t_run(1'b1, 0, 'h3F);
    t_run(1'b1, 2, 'h15);
    t_busy_start();
    t_back_to_back();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule